// File: doc/BRIEF.md
# Serial Interrupt-Enable and Event Controller

This block is the interrupt side of a supply-supervision controller. A host reaches it through a 16-bit SPI slave port. Each frame can rewrite a register of seven interrupt enables, and its reply returns either the latched interrupt flags or a read-back of the enables. The block watches a set of digital status lines: watchdog overflow, temperature warning, ground-shift warning, a battery sense line, three supply-failure flags and the CAN failure status. When a qualifying change is seen on a line whose enable is set, the block latches the matching flag. An active-low interrupt line is driven while any flag is both latched and enabled. Some faults request a system reset instead, depending on the operating mode.

The SPI pins and the status lines are asynchronous. They are brought into the system clock domain through two-flop synchronizers, and the SPI edges are detected by oversampling. A frame is acted on only when it carried exactly sixteen clock pulses. Any other count throws the frame away, and such a frame can raise an interrupt or a reset request. Reading the flags clears the flags that the reply reported.

Top module: `irq_enable_ctrl`

## Requirements
- R1: Frames are shifted MSB first, with MOSI sampled on SCK rising edges, and are acted on when CSN rises. Bits 15:14 must equal 01. Any other address gives no enable write and no flag clear, and the reply data is all zeros.
- R2: Bit 13 selects the reply. A 1 returns the latched flags and a 0 returns the enable register. The returned bits sit at 11:5 and every other reply bit is 0. MISO changes only on SCK falling edges, and it holds 0 while CSN is high.
- R3: Bit 12 = 0 loads the enable register from bits 11:5. Bit 12 = 1 leaves it unchanged. The field order is 11 watchdog, 10 temperature, 9 ground shift, 8 clock-count failure, 7 battery, 6 supply, 5 CAN. The reply is taken from the register contents at CSN fall.
- R4: A valid frame with address 01 and bit 13 = 1 clears exactly those flags that its reply reported.
- R5: A frame with a clock count other than 16 (zero included) changes neither register. If the clock-count enable is set, it raises that flag in mode 00 (normal) or 01 (standby). In mode 1x (start-up/restart) it gives one reset-request pulse instead.
- R6: A rising edge on the watchdog-overflow line sets the watchdog flag if the mode is standby (01) and the watchdog enable is set. In every other case it gives a reset-request pulse.
- R7: When enabled, either edge of the temperature-warning line sets its flag. Either edge of the ground-shift line does the same for the ground-shift flag.
- R8: When enabled, a falling edge of the sense line sets the battery flag. A rising edge does not.
- R9: When enabled, any supply-failure bit going 1 to 0 sets the supply flag. A 0 to 1 change does not.
- R10: When enabled, any change of the CAN failure status bits sets the CAN flag.
- R11: A flag is set only while its enable is set. The interrupt output is low exactly when some flag is latched with its enable set.
- R12: After reset, enables and flags are zero, the interrupt output is high, the reset request is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock from the host |
| mosi | input | 1 | SPI data from the host |
| csN | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI reply data |
| mode | input | 2 | 00 normal, 01 standby, 1x start-up/restart |
| wdOverflow | input | 1 | Watchdog overflow event (rising edge) |
| tempWarn | input | 1 | Temperature-warning comparator level |
| gndShift | input | 1 | Ground-shift comparator level |
| sense | input | 1 | Battery sense level |
| supplyFail | input | SUP_W | Supply-failure flags |
| canFail | input | CAN_W | CAN failure status bits |
| intN | output | 1 | Interrupt output, active low |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
The bench goes after frames with 0, 15 and 17 clocks in each mode. A design that counted loosely would load the enable data those frames carry, or give an interrupt where a reset is due. It toggles each status line both ways, so a detector with the wrong edge polarity would set the battery or supply flag on recovery instead of on failure. Read-only frames, frames to a foreign address and flag reads made after an enable change show whether a design writes when it should not, or clears flags it never reported. Watchdog overflows in every mode, with the enable set and clear, show whether an interrupt is given in place of a reset outside standby.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int EN_W       = 7;
  localparam int EN_LSB     = 5;
  localparam int KEEP_W     = FRAME_BITS - EN_LSB;

  localparam logic [1:0] REG_ADDR     = 2'b01;
  localparam logic [1:0] MODE_STANDBY = 2'b01;

  localparam int B_WD   = 6;
  localparam int B_TEMP = 5;
  localparam int B_GND  = 4;
  localparam int B_SPI  = 3;
  localparam int B_BAT  = 2;
  localparam int B_VOLT = 1;
  localparam int B_CAN  = 0;

  typedef struct packed {
    logic            frameStart;
    logic            frameValid;
    logic            frameBad;
    logic            writeEn;
    logic            clearRead;
    logic [EN_W-1:0] wrData;
  } ctrlStb_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_spi_ctrl.sv
module irqc_spi_ctrl
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sckS,
  input  logic            mosiS,
  input  logic            csNS,
  input  logic [EN_W-1:0] snapFlags,
  input  logic [EN_W-1:0] snapEn,
  output ctrlStb_t        stb,
  output logic            miso
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int IDX_W   = $clog2(FRAME_BITS);

  logic sckQ, csNQ;
  logic sckRise, sckFall, csFall, csRise, active;
  logic [CNT_W-1:0]      bitCnt;
  logic [KEEP_W-1:0]     keepReg;
  logic [1:0]            addrReg;
  logic                  rrsReg;
  logic [FRAME_BITS-1:0] replyWord;
  logic [IDX_W-1:0]      bitIdx;
  logic                  misoNext;
  logic                  lenOk, addrOk;

  assign sckRise = sckS & ~sckQ;
  assign sckFall = ~sckS & sckQ;
  assign csFall  = ~csNS & csNQ;
  assign csRise  = csNS & ~csNQ;
  assign active  = ~csNS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csNQ <= 1'b1;
    end else begin
      sckQ <= sckS;
      csNQ <= csNS;
    end
  end

  // Bit counter and header capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      keepReg <= '0;
      addrReg <= '0;
      rrsReg  <= 1'b0;
    end else if (csFall) begin
      bitCnt  <= '0;
      addrReg <= '0;
      rrsReg  <= 1'b0;
    end else if (active && sckRise) begin
      if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
      if (bitCnt < CNT_W'(KEEP_W)) keepReg <= {keepReg[KEEP_W-2:0], mosiS};
      if (bitCnt == CNT_W'(0)) addrReg[1] <= mosiS;
      if (bitCnt == CNT_W'(1)) addrReg[0] <= mosiS;
      if (bitCnt == CNT_W'(2)) rrsReg     <= mosiS;
    end
  end

  always_comb begin
    replyWord = '0;
    if (addrReg == REG_ADDR)
      replyWord[EN_LSB +: EN_W] = rrsReg ? snapFlags : snapEn;
  end

  assign bitIdx = IDX_W'(FRAME_BITS - 1) - IDX_W'(bitCnt);

  always_comb begin
    misoNext = 1'b0;
    if (bitCnt < CNT_W'(FRAME_BITS)) misoNext = replyWord[bitIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  miso <= 1'b0;
    else if (csFall || csRise)  miso <= 1'b0;
    else if (active && sckFall) miso <= misoNext;
  end

  // Strobes towards the datapath
  assign lenOk  = (bitCnt == CNT_W'(FRAME_BITS));
  assign addrOk = (keepReg[KEEP_W-1 -: 2] == REG_ADDR);

  always_comb begin
    stb            = '0;
    stb.frameStart = csFall;
    stb.frameValid = csRise & lenOk;
    stb.frameBad   = csRise & ~lenOk;
    stb.writeEn    = csRise & lenOk & addrOk & ~keepReg[KEEP_W-4];
    stb.clearRead  = csRise & lenOk & addrOk &  keepReg[KEEP_W-3];
    stb.wrData     = keepReg[EN_W-1:0];
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.frameStart, stb.frameValid, stb.frameBad})); // R5
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameBad |-> (!stb.writeEn && !stb.clearRead)); // R5
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csNS && csNQ) |-> !miso); // R2
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SUP_W = 3,
  parameter int CAN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [1:0]       mode,
  input  logic             wdS,
  input  logic             tempS,
  input  logic             gndS,
  input  logic             senseS,
  input  logic [SUP_W-1:0] supS,
  input  logic [CAN_W-1:0] canS,
  output logic [EN_W-1:0]  snapFlags,
  output logic [EN_W-1:0]  snapEn,
  output logic             intN,
  output logic             resetReq
);
  logic [EN_W-1:0]  enReg, flagReg, evt, clrMask;
  logic             wdQ, tempQ, gndQ, senseQ;
  logic [SUP_W-1:0] supQ;
  logic [CAN_W-1:0] canQ;
  logic             wdRise, wdIrq, startMode, rstNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdQ    <= 1'b0;
      tempQ  <= 1'b0;
      gndQ   <= 1'b0;
      senseQ <= 1'b1;
      supQ   <= '0;
      canQ   <= '0;
    end else begin
      wdQ    <= wdS;
      tempQ  <= tempS;
      gndQ   <= gndS;
      senseQ <= senseS;
      supQ   <= supS;
      canQ   <= canS;
    end
  end

  assign wdRise    = wdS & ~wdQ;
  assign startMode = mode[1];
  assign wdIrq     = (mode == MODE_STANDBY) & enReg[B_WD];

  always_comb begin
    evt         = '0;
    evt[B_WD]   = wdRise & wdIrq;
    evt[B_TEMP] = tempS ^ tempQ;
    evt[B_GND]  = gndS ^ gndQ;
    evt[B_SPI]  = stb.frameBad & ~startMode;
    evt[B_BAT]  = ~senseS & senseQ;
    evt[B_VOLT] = |(~supS & supQ);
    evt[B_CAN]  = |(canS ^ canQ);
    evt         = evt & enReg;
  end

  assign rstNext = (wdRise & ~wdIrq) | (stb.frameBad & startMode & enReg[B_SPI]);
  assign clrMask = stb.clearRead ? snapFlags : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      flagReg   <= '0;
      snapFlags <= '0;
      snapEn    <= '0;
      resetReq  <= 1'b0;
    end else begin
      if (stb.writeEn) enReg <= stb.wrData;
      flagReg  <= (flagReg & ~clrMask) | evt;
      resetReq <= rstNext;
      if (stb.frameStart) begin
        snapFlags <= flagReg;
        snapEn    <= enReg;
      end
    end
  end

  assign intN = ~|(flagReg & enReg);

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeEn |=> $stable(enReg)); // R3
  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg & ~$past(flagReg) & ~$past(enReg)) == '0); // R11
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irqc_pkg::*;
#(
  parameter int SUP_W  = 3,
  parameter int CAN_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             mosi,
  input  logic             csN,
  output logic             miso,
  input  logic [1:0]       mode,
  input  logic             wdOverflow,
  input  logic             tempWarn,
  input  logic             gndShift,
  input  logic             sense,
  input  logic [SUP_W-1:0] supplyFail,
  input  logic [CAN_W-1:0] canFail,
  output logic             intN,
  output logic             resetReq
);
  logic [2:0]       spiS;
  logic [2:0]       lvlS;
  logic             senseS;
  logic [SUP_W-1:0] supS;
  logic [CAN_W-1:0] canS;
  ctrlStb_t         stb;
  logic [EN_W-1:0]  snapFlags, snapEn;

  irqc_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) uSyncSpi (
    .clk(clk), .rstN(rstN), .d({csN, mosi, sck}), .q(spiS));
  irqc_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b000)) uSyncLvl (
    .clk(clk), .rstN(rstN), .d({wdOverflow, tempWarn, gndShift}), .q(lvlS));
  irqc_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) uSyncSense (
    .clk(clk), .rstN(rstN), .d(sense), .q(senseS));
  irqc_sync #(.W(SUP_W), .STAGES(STAGES), .RST_VAL('0)) uSyncSup (
    .clk(clk), .rstN(rstN), .d(supplyFail), .q(supS));
  irqc_sync #(.W(CAN_W), .STAGES(STAGES), .RST_VAL('0)) uSyncCan (
    .clk(clk), .rstN(rstN), .d(canFail), .q(canS));

  irqc_spi_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sckS(spiS[0]), .mosiS(spiS[1]), .csNS(spiS[2]),
    .snapFlags(snapFlags), .snapEn(snapEn),
    .stb(stb), .miso(miso));

  irqc_datapath #(.SUP_W(SUP_W), .CAN_W(CAN_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode),
    .wdS(lvlS[2]), .tempS(lvlS[1]), .gndS(lvlS[0]), .senseS(senseS),
    .supS(supS), .canS(canS),
    .snapFlags(snapFlags), .snapEn(snapEn),
    .intN(intN), .resetReq(resetReq));
endmodule

// File: tb/irq_enable_ctrl_bench.sv
module irq_enable_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csN = 1'b1, miso;
  logic [1:0] mode = 2'b00;
  logic wd = 1'b0, temp = 1'b0, gnd = 1'b0, sense = 1'b1;
  logic [2:0] supply = 3'b000;
  logic [1:0] can = 2'b00;
  logic intN, resetReq;

  int nChecks = 0, nFail = 0, rstCnt = 0, expRst = 0;
  bit done = 0;
  logic [6:0] expEn = '0, expFlags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (resetReq === 1'b1) rstCnt++;

  irq_enable_ctrl u_irq_enable_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN), .miso(miso),
    .mode(mode), .wdOverflow(wd), .tempWarn(temp), .gndShift(gnd),
    .sense(sense), .supplyFail(supply), .canFail(can),
    .intN(intN), .resetReq(resetReq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(string req);
    chk(req, 32'(intN), 32'(~|(expFlags & expEn)), "intN");
    chk(req, rstCnt, expRst, "reset pulses");
  endtask

  task automatic spiXfer(input logic [15:0] tx, input int nClk, output logic [15:0] rx);
    rx = '0;
    csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nClk; i++) begin
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [15:0] expReply(logic [15:0] tx, logic [6:0] f, logic [6:0] e);
    logic [15:0] r = '0;
    if (tx[15:14] == 2'b01) r[11:5] = tx[13] ? f : e;
    return r;
  endfunction

  task automatic doFrame(input logic [15:0] tx, input int nClk, input string req);
    logic [15:0] rx;
    logic [6:0] snapF = expFlags, snapE = expEn;
    spiXfer(tx, nClk, rx);
    if (nClk == 16) begin
      chk(req, 32'(rx), 32'(expReply(tx, snapF, snapE)), "reply");
      if (tx[15:14] == 2'b01) begin
        if (!tx[12]) expEn = tx[11:5];
        if (tx[13]) expFlags &= ~snapF;
      end
    end else if (expEn[3]) begin
      if (mode[1]) expRst++;
      else expFlags[3] = 1'b1;
    end
    checkOut(req);
  endtask

  task automatic settle(string req);
    repeat (12) @(negedge clk);
    checkOut(req);
  endtask

  task automatic writeEn(logic [6:0] e, string req);
    doFrame({2'b01, 1'b0, 1'b0, e, 5'b0}, 16, req);
  endtask

  task automatic setTemp(logic v, string req);
    if (v != temp && expEn[5]) expFlags[5] = 1'b1;
    temp = v; settle(req);
  endtask
  task automatic setGnd(logic v, string req);
    if (v != gnd && expEn[4]) expFlags[4] = 1'b1;
    gnd = v; settle(req);
  endtask
  task automatic setSense(logic v, string req);
    if (sense && !v && expEn[2]) expFlags[2] = 1'b1;
    sense = v; settle(req);
  endtask
  task automatic setSupply(logic [2:0] v, string req);
    if (|(supply & ~v) && expEn[1]) expFlags[1] = 1'b1;
    supply = v; settle(req);
  endtask
  task automatic setCan(logic [1:0] v, string req);
    if (v != can && expEn[0]) expFlags[0] = 1'b1;
    can = v; settle(req);
  endtask
  task automatic pulseWd(string req);
    if (mode == 2'b01 && expEn[6]) expFlags[6] = 1'b1;
    else expRst++;
    wd = 1'b1; repeat (4) @(negedge clk); wd = 1'b0;
    settle(req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R12", 32'(intN), 1, "intN in reset");
    chk("R12", 32'(resetReq), 0, "resetReq in reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12", 32'(miso), 0, "miso after reset");
    checkOut("R12");
    doFrame(16'h5000, 16, "R12");           // enable feedback is zero
    doFrame(16'h7000, 16, "R12");           // flags are zero

    writeEn(7'h7F, "R3");
    doFrame(16'h5000, 16, "R3");            // feedback 7F at 11:5
    doFrame(16'h5000 | 16'h0AA0, 16, "R3"); // read-only: data ignored
    doFrame(16'h8000 | 16'h0140, 16, "R1"); // address 10: reply 0, no write
    doFrame(16'h5000, 16, "R1");

    setTemp(1'b1, "R7");
    setTemp(1'b0, "R7");
    doFrame(16'h7000, 16, "R4");            // flags reported and cleared
    doFrame(16'h7000, 16, "R4");            // now empty
    setGnd(1'b1, "R7");
    setSense(1'b0, "R8");
    doFrame(16'h7000, 16, "R8");
    setSense(1'b1, "R8");                   // rising edge: nothing
    doFrame(16'h7000, 16, "R8");
    setSupply(3'b010, "R9");                // 0->1: nothing
    doFrame(16'h7000, 16, "R9");
    setSupply(3'b000, "R9");
    setCan(2'b01, "R10");
    doFrame(16'h7000, 16, "R10");

    mode = 2'b00;
    doFrame(16'h4000 | 16'h0020, 15, "R5"); // short frame, normal mode
    doFrame(16'h7000, 16, "R5");
    doFrame(16'h4000, 0, "R5");             // no clocks at all
    mode = 2'b10;
    doFrame(16'h4000, 17, "R5");            // long frame in start-up: reset
    doFrame(16'h5000, 16, "R5");            // enables unchanged
    mode = 2'b01;
    pulseWd("R6");                          // standby + enable: interrupt
    mode = 2'b00;
    pulseWd("R6");                          // normal: reset
    doFrame(16'h7000, 16, "R6");
    writeEn(7'h00, "R11");
    mode = 2'b01;
    pulseWd("R6");                          // enable clear: reset
    setTemp(1'b1, "R11");
    setCan(2'b10, "R11");
    doFrame(16'h7000, 16, "R11");

    for (int it = 0; it < 150; it++) begin
      logic [15:0] tx;
      int n;
      mode = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 8))
        0: begin
          tx = 16'($urandom);
          if ($urandom_range(0, 3) != 0) tx[15:14] = 2'b01;
          doFrame(tx, 16, "R3");
        end
        1: doFrame(16'h7000, 16, "R4");
        2: setTemp(~temp, "R7");
        3: setGnd(~gnd, "R7");
        4: setSense(~sense, "R8");
        5: setSupply(3'($urandom), "R9");
        6: setCan(2'($urandom), "R10");
        7: pulseWd("R6");
        default: begin
          n = $urandom_range(0, 20);
          if (n == 16) n = 17;
          doFrame(16'($urandom), n, "R5");
        end
      endcase
    end
    doFrame(16'h5000, 16, "R2");
    doFrame(16'h7000, 16, "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule